// File: doc/BRIEF.md
# Sixteen-Line General-Purpose I/O Port with Edge Interrupts

This block is a 16-line general-purpose I/O port behind a small synchronous register port. Each line can be an input or an output. An output line drives the value held in its output latch. An input line is sampled once per clock. On an input line that is not masked, a transition of the chosen polarity sets a sticky status bit. A single interrupt output stays high while any status bit is set. Software clears status bits by writing ones to them.

Register access uses a one-cycle strobe with address, write enable, access-width flag and write data. Read data is combinational and valid in the cycle the strobe is high. Writes take effect at the clock edge that ends the strobe cycle. The port carries no streaming data, so there is no valid/ready handshake and no back-pressure.

Top module: `gpio16_port`

## Requirements
- R1: After reset, the output latch, direction, polarity, mask and pin-qualify registers all read 0xFFFF. The status register reads 0x0000. `irq` is low, `pin_oe` is 0x0000 and `pin_out` is 0x0000.
- R2: `pin_oe` equals the inverse of the direction register, where a 1 means input. `pin_out` equals the output latch on lines whose direction bit is 0 and is 0 on other lines. A write to the output latch or to the direction register shows on the pins from the clock edge that ends the write.
- R3: A polarity bit of 1 selects rising transitions and 0 selects falling ones. A pin change that is captured at clock edge k sets its status bit at edge k+1.
- R4: A line whose direction bit is 0, or whose mask bit is 1, never sets its status bit.
- R5: `irq` is high exactly while at least one status bit is set. It stays high until software clears the status bits.
- R6: Writing to the status register clears the bits written as 1 and leaves the bits written as 0. If a new transition arrives in the same cycle as a clear of the same bit, the bit stays set.
- R7: A read of the input register returns the sampled pins ANDed bitwise with the pin-qualify register.
- R8: An access with `bus_full` = 0 (any width other than 16 bits) reads as 0x0000 and writes nothing.
- R9: Writes to the input register (0x00) and to undefined offsets change nothing. Undefined offsets read as 0x0000.
- R10: The register offsets are: 0x00 input (read-only), 0x04 output latch, 0x08 direction, 0x0C polarity, 0x10 mask, 0x14 status, 0x18 pin-qualify.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_full | input | 1 | 1 = 16-bit access; any other width is rejected |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational |
| pin_in | input | 16 | Pin levels seen by the port |
| pin_out | output | 16 | Driven pin values |
| pin_oe | output | 16 | Per-line output enable |
| irq | output | 1 | Interrupt, high while any status bit is set |

## Verification
Separate lines see rising transitions, falling transitions, and transitions against the selected polarity. This shows that the polarity bit, and not just any toggle, decides detection. The same toggles are repeated on a masked line and on an output line, which separates the two gating terms. A transition that lands in the same cycle as a clear of its status bit checks that the set wins. Partial clears check that only the bits written as 1 are cleared. A mixed pin pattern read through a partial pin-qualify mask, together with narrow and undefined accesses, checks the decode.

// File: rtl/gpio16_pkg.sv
package gpio16_pkg;
  localparam int unsigned OFS_DIN  = 'h00;
  localparam int unsigned OFS_DOUT = 'h04;
  localparam int unsigned OFS_DIR  = 'h08;
  localparam int unsigned OFS_POL  = 'h0C;
  localparam int unsigned OFS_MASK = 'h10;
  localparam int unsigned OFS_STAT = 'h14;
  localparam int unsigned OFS_QUAL = 'h18;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_DIN, SEL_DOUT, SEL_DIR, SEL_POL, SEL_MASK, SEL_STAT, SEL_QUAL
  } reg_sel_e;
endpackage

// File: rtl/gpio16_regfile.sv
module gpio16_regfile
  import gpio16_pkg::*;
#(
  parameter int N  = 16,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel,
  input  logic          we,
  input  logic          full,
  input  logic [AW-1:0] addr,
  input  logic [N-1:0]  wdata,
  input  logic [N-1:0]  sample,
  input  logic [N-1:0]  status,
  output logic [N-1:0]  dout,
  output logic [N-1:0]  dir,
  output logic [N-1:0]  pol,
  output logic [N-1:0]  mask,
  output logic [N-1:0]  qual,
  output logic [N-1:0]  stat_clr,
  output logic [N-1:0]  rdata
);
  reg_sel_e rsel;
  logic     wr;

  always_comb begin
    unique case (addr)
      AW'(OFS_DIN):  rsel = SEL_DIN;
      AW'(OFS_DOUT): rsel = SEL_DOUT;
      AW'(OFS_DIR):  rsel = SEL_DIR;
      AW'(OFS_POL):  rsel = SEL_POL;
      AW'(OFS_MASK): rsel = SEL_MASK;
      AW'(OFS_STAT): rsel = SEL_STAT;
      AW'(OFS_QUAL): rsel = SEL_QUAL;
      default:       rsel = SEL_NONE;
    endcase
  end

  assign wr       = sel & we & full;
  assign stat_clr = (wr && rsel == SEL_STAT) ? wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout <= '1;
      dir  <= '1;
      pol  <= '1;
      mask <= '1;
      qual <= '1;
    end else if (wr) begin
      case (rsel)
        SEL_DOUT: dout <= wdata;
        SEL_DIR:  dir  <= wdata;
        SEL_POL:  pol  <= wdata;
        SEL_MASK: mask <= wdata;
        SEL_QUAL: qual <= wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata = '0;
    if (full) begin
      case (rsel)
        SEL_DIN:  rdata = sample & qual;
        SEL_DOUT: rdata = dout;
        SEL_DIR:  rdata = dir;
        SEL_POL:  rdata = pol;
        SEL_MASK: rdata = mask;
        SEL_STAT: rdata = status;
        SEL_QUAL: rdata = qual;
        default:  rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/gpio16_detect.sv
module gpio16_detect #(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin_in,
  input  logic [N-1:0] dir,
  input  logic [N-1:0] pol,
  input  logic [N-1:0] mask,
  input  logic [N-1:0] stat_clr,
  output logic [N-1:0] sample,
  output logic [N-1:0] hit,
  output logic [N-1:0] status
);
  logic [N-1:0] prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sample <= '0;
      prev   <= '0;
    end else begin
      sample <= pin_in;
      prev   <= sample;
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_line
    logic rise, fall;
    assign rise   = sample[i] & ~prev[i];
    assign fall   = ~sample[i] & prev[i];
    assign hit[i] = dir[i] & ~mask[i] & (pol[i] ? rise : fall);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        status[i] <= 1'b0;
      else if (hit[i])   status[i] <= 1'b1;
      else if (stat_clr[i]) status[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/gpio16_port.sv
module gpio16_port #(
  parameter int N_LINES = 16,
  parameter int ADDR_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_sel,
  input  logic               bus_we,
  input  logic               bus_full,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [N_LINES-1:0] bus_wdata,
  output logic [N_LINES-1:0] bus_rdata,
  input  logic [N_LINES-1:0] pin_in,
  output logic [N_LINES-1:0] pin_out,
  output logic [N_LINES-1:0] pin_oe,
  output logic               irq
);
  logic [N_LINES-1:0] dout, dir, pol, mask, qual;
  logic [N_LINES-1:0] stat_clr, sample, hit_vec, stat_q;

  gpio16_regfile #(.N(N_LINES), .AW(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .sel(bus_sel), .we(bus_we), .full(bus_full),
    .addr(bus_addr), .wdata(bus_wdata), .sample(sample), .status(stat_q),
    .dout(dout), .dir(dir), .pol(pol), .mask(mask), .qual(qual),
    .stat_clr(stat_clr), .rdata(bus_rdata)
  );

  gpio16_detect #(.N(N_LINES)) u_det (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .dir(dir), .pol(pol),
    .mask(mask), .stat_clr(stat_clr), .sample(sample), .hit(hit_vec),
    .status(stat_q)
  );

  assign pin_oe  = ~dir;
  assign pin_out = dout & ~dir;
  assign irq     = |stat_q;
endmodule

// File: rtl/gpio16_port_chk.sv
module gpio16_port_chk
  import gpio16_pkg::*;
#(
  parameter int N  = 16,
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_sel,
  input logic          bus_we,
  input logic          bus_full,
  input logic [AW-1:0] bus_addr,
  input logic [N-1:0]  bus_wdata,
  input logic [N-1:0]  bus_rdata,
  input logic [N-1:0]  pin_out,
  input logic [N-1:0]  pin_oe,
  input logic          irq,
  input logic [N-1:0]  hit
);
  logic wr_ok;
  assign wr_ok = bus_sel & bus_we & bus_full;

  p_dir_oe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && bus_addr == AW'(OFS_DIR)) |=> pin_oe == ~$past(bus_wdata));

  p_dout_drive_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && bus_addr == AW'(OFS_DOUT)) |=> pin_out == ($past(bus_wdata) & pin_oe));

  p_hit_raises_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|hit) |=> irq);

  p_irq_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !(wr_ok && bus_addr == AW'(OFS_STAT))) |=> irq);

  p_clear_all_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && bus_addr == AW'(OFS_STAT) && bus_wdata == '1 && hit == '0) |=> !irq);

  p_narrow_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_we && !bus_full) |-> bus_rdata == '0);
endmodule

bind gpio16_port gpio16_port_chk #(.N(N_LINES), .AW(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
  .bus_full(bus_full), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq),
  .hit(hit_vec)
);

// File: tb/sim_gpio16_port.sv
module sim_gpio16_port;
  logic        clk = 0, rst_n = 0;
  logic        bus_sel = 0, bus_we = 0, bus_full = 1;
  logic [7:0]  bus_addr = 0;
  logic [15:0] bus_wdata = 0, bus_rdata, pin_in = 0, pin_out, pin_oe;
  logic        irq;
  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  gpio16_port u0 (.*);

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [15:0] d, bit full = 1);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d; bus_full = full;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 0; bus_we = 0; bus_full = 1;
  endtask

  task automatic rd(logic [7:0] a, output logic [15:0] d, input bit full = 1);
    @(negedge clk);
    bus_sel = 1; bus_we = 0; bus_addr = a; bus_full = full;
    #1 d = bus_rdata;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 0; bus_full = 1;
  endtask

  task automatic pins(logic [15:0] v);
    @(negedge clk); pin_in = v;
    repeat (2) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset;
    logic [15:0] d;
    chk("R1 oe", pin_oe, 16'h0000);
    chk("R1 out", pin_out, 16'h0000);
    chk("R1 irq", {15'd0, irq}, 16'h0);
    rd(8'h04, d); chk("R1 dout", d, 16'hFFFF);
    rd(8'h08, d); chk("R1 dir", d, 16'hFFFF);
    rd(8'h0C, d); chk("R1 pol", d, 16'hFFFF);
    rd(8'h10, d); chk("R1 mask", d, 16'hFFFF);
    rd(8'h14, d); chk("R1 stat", d, 16'h0000);
    rd(8'h18, d); chk("R1 qual", d, 16'hFFFF);
  endtask

  task automatic t_drive;
    wr(8'h04, 16'h1234);
    wr(8'h08, 16'hFF00);
    chk("R2 oe", pin_oe, 16'h00FF);
    chk("R2 out", pin_out, 16'h0034);
    wr(8'h08, 16'hF0F0);
    chk("R2 out after dir change", pin_out, 16'h0204);
    wr(8'h08, 16'hFFFF);
    wr(8'h04, 16'hFFFF);
    chk("R2 all input", pin_out, 16'h0000);
  endtask

  task automatic t_edges;
    logic [15:0] d;
    wr(8'h10, 16'hFFF5);          // unmask lines 3 and 1
    wr(8'h0C, 16'hFFFD);          // line 1 falling, line 3 rising
    @(negedge clk); pin_in = 16'h0002;  // rising on line 1: wrong polarity
    @(posedge clk); @(negedge clk);
    chk("R3 latency: not yet", {15'd0, irq}, 16'h0);
    @(posedge clk); @(negedge clk);
    chk("R3 wrong polarity ignored", {15'd0, irq}, 16'h0);
    pins(16'h000A);               // rising on line 3
    rd(8'h14, d); chk("R3 rising sets", d, 16'h0008);
    chk("R5 irq high", {15'd0, irq}, 16'h1);
    pins(16'h0008);               // falling on line 1
    rd(8'h14, d); chk("R3 falling sets", d, 16'h000A);
  endtask

  task automatic t_clear;
    logic [15:0] d;
    wr(8'h14, 16'h0000);
    rd(8'h14, d); chk("R6 zero write", d, 16'h000A);
    wr(8'h14, 16'h0002);
    rd(8'h14, d); chk("R6 partial clear", d, 16'h0008);
    chk("R5 irq stays", {15'd0, irq}, 16'h1);
    wr(8'h14, 16'h0008);
    chk("R5 irq drops", {15'd0, irq}, 16'h0);
    // set wins over a clear in the same cycle
    @(negedge clk); pin_in = 16'h0000;   // falling on line 3 (rising pol): none
    repeat (2) @(posedge clk);
    @(negedge clk); pin_in = 16'h0008;
    @(posedge clk);
    wr(8'h14, 16'h0008);
    rd(8'h14, d); chk("R6 set wins", d, 16'h0008);
    wr(8'h14, 16'hFFFF);
  endtask

  task automatic t_gate;
    logic [15:0] d;
    pins(16'h0000);
    wr(8'h14, 16'hFFFF);
    pins(16'h0020);               // line 5 masked
    rd(8'h14, d); chk("R4 masked line", d, 16'h0000);
    wr(8'h08, 16'hFFF7);          // line 3 output
    pins(16'h0028);
    rd(8'h14, d); chk("R4 output line", d, 16'h0000);
    chk("R4 irq low", {15'd0, irq}, 16'h0);
    wr(8'h08, 16'hFFFF);
  endtask

  task automatic t_din;
    logic [15:0] d;
    wr(8'h10, 16'hFFFF);
    wr(8'h18, 16'h00FF);
    pins(16'hA5A5);
    rd(8'h00, d); chk("R7 qualified input", d, 16'h00A5);
    wr(8'h18, 16'hFFFF);
    rd(8'h00, d); chk("R7 full input", d, 16'hA5A5);
  endtask

  task automatic t_width;
    logic [15:0] d;
    wr(8'h10, 16'h1234, 0);
    rd(8'h10, d); chk("R8 narrow write ignored", d, 16'hFFFF);
    rd(8'h10, d, 0); chk("R8 narrow read zero", d, 16'h0000);
  endtask

  task automatic t_undef;
    logic [15:0] d;
    wr(8'h00, 16'h0000);
    rd(8'h00, d); chk("R9 input write ignored", d, 16'hA5A5);
    wr(8'h1C, 16'h0000);
    wr(8'h02, 16'h0000);
    rd(8'h1C, d); chk("R9 undefined reads zero", d, 16'h0000);
    rd(8'h10, d); chk("R10 mask intact", d, 16'hFFFF);
    rd(8'h04, d); chk("R10 dout intact", d, 16'hFFFF);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    t_reset; t_drive; t_edges; t_clear; t_gate; t_din; t_width; t_undef;
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog act=hung exp=done");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule